// File: doc/BRIEF.md
# Configuration Image Header Parser

This block takes a configuration image one byte at a time over a valid/ready input and walks its header. First it checks a fixed 13-byte signature. Next it steps through four text information sections. Each section has a tag byte, a 16-bit big-endian length and that many content bytes. The block then requires a length tag of ASCII `e`, reads a 32-bit big-endian payload length, and forwards exactly that many payload bytes to a downstream valid/ready port. Every content byte of an information section appears on a side output as it is accepted. The side output also gives the byte's field index and first/last markers. The text itself is not stored.

The controller is a single state machine with these states:
- `ST_SIG`: compares the signature bytes.
- `ST_TAG`: consumes a section tag.
- `ST_LEN_HI` and `ST_LEN_LO`: read the section length.
- `ST_BODY`: emits content bytes.
- `ST_LTAG`: checks the payload length tag.
- `ST_PLEN`: reads the payload length.
- `ST_PAY`: forwards the payload.
- `ST_ERR`: holds the block after an error.

The transitions are:
- `ST_SIG` goes to `ST_TAG` after the last signature byte, or to `ST_ERR` on a mismatch.
- `ST_TAG` goes to `ST_LEN_HI`, and `ST_LEN_HI` goes to `ST_LEN_LO`.
- `ST_LEN_LO` goes to `ST_BODY` for a non-zero length, to `ST_ERR` for an oversize length, or directly to the next section for a zero length.
- When a section ends, `ST_BODY` goes to `ST_TAG` (the next field), or to `ST_LTAG` after the fourth field.
- `ST_LTAG` goes to `ST_PLEN`, or to `ST_ERR` for a wrong tag.
- `ST_PLEN` goes to `ST_PAY`, or directly to `ST_SIG` for a zero length.
- `ST_PAY` goes to `ST_SIG` after the last payload byte.
- A synchronous `restart` returns the block to `ST_SIG` from any state.

Top module: `cfg_hdr_parser`

## Requirements
- R1: After reset or a `restart` pulse, the block shows this state: `in_ready`=1, `err_code`=0, `hdr_done`=0, `pay_len`=0, `done`=0, `info_valid`=0 and `pay_valid`=0.
- R2: The first 13 accepted bytes must be 0x00, 0x09, 0x0F, 0xF0, 0x0F, 0xF0, 0x0F, 0xF0, 0x0F, 0xF0, 0x00, 0x00, 0x01, in that order. Any mismatching byte sets `err_code` to 1 on the edge that accepts it.
- R3: Four information sections follow the signature. Their content bytes appear on `info_data` with `info_valid` in the same cycle as they are accepted. `info_field` is 0 for the design name, 1 for the device part, 2 for the date and 3 for the time.
- R4: Each section is one tag byte (any value, not checked), a big-endian 16-bit length (high byte first), and the content. `info_first` marks the first content byte and `info_last` marks the last. A section of length 0 emits nothing.
- R5: A section length of 256 or more sets `err_code` to 2 on the edge that accepts the low length byte. A length of 255 is accepted.
- R6: The byte after the fourth section must be 0x65. Any other value sets `err_code` to 3.
- R7: The next four bytes form the payload length, most significant byte first. It is shown on `pay_len`, and `hdr_done` is 1 from the edge that accepts the fourth byte. `pay_len` does not change while the payload flows.
- R8: Exactly `pay_len` payload bytes go out on `pay_data`/`pay_valid`. `done` is high for the single cycle after the last one is accepted, and the block then expects a new signature. A zero length gives `done` right after the length bytes.
- R9: During the payload, `in_ready` follows `pay_ready`, so a stalled downstream port holds the input.
- R10: An error code stays until `restart`. Meanwhile all input is accepted and dropped, with no `info_valid` or `pay_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous return to the signature state; clears status |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with `in_valid` |
| in_data | input | 8 | Input byte |
| info_valid | output | 1 | Information content byte present |
| info_field | output | 2 | Field index of that byte |
| info_first | output | 1 | First content byte of the section |
| info_last | output | 1 | Last content byte of the section |
| info_data | output | 8 | Content byte |
| pay_valid | output | 1 | Payload byte present |
| pay_ready | input | 1 | Downstream accepts payload byte |
| pay_data | output | 8 | Payload byte |
| pay_len | output | 32 | Parsed payload length |
| hdr_done | output | 1 | Header fully parsed |
| done | output | 1 | One-cycle pulse after the final payload byte |
| err_code | output | 2 | Sticky error: 0 none, 1 signature, 2 section length, 3 length tag |

## Verification
The hardest conditions to reach are a stall on the last payload byte, and a done pulse that coincides with a stall just lifted. The bench reaches them by running many images with random section and payload lengths while it randomly lowers `pay_ready`. Directed images cover the other hard cases:
- zero-length sections and a zero-length payload, where a state is skipped;
- a section length of exactly 255 and of 256;
- errors injected partway through the header, followed by extra input to show it is dropped, then a restart and a clean image to show recovery.

// File: rtl/cfg_hdr_pkg.sv
`timescale 1ns/1ps
package cfg_hdr_pkg;
    localparam int SIG_BYTES = 13;
    localparam int SIG_IDX_W = 4;
    localparam int NUM_INFO  = 4;
    localparam int ILEN_W    = 16;
    localparam logic [7:0] LEN_TAG = 8'h65;

    typedef enum logic [3:0] {
        ST_SIG, ST_TAG, ST_LEN_HI, ST_LEN_LO, ST_BODY,
        ST_LTAG, ST_PLEN, ST_PAY, ST_ERR
    } state_t;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_MAGIC    = 2'd1,
        ERR_INFO_LEN = 2'd2,
        ERR_LEN_TAG  = 2'd3
    } err_t;

    // Expected signature byte at a given position
    function automatic logic [7:0] sig_byte(input logic [SIG_IDX_W-1:0] idx);
        logic [7:0] b;
        case (idx)
            4'd0, 4'd10, 4'd11: b = 8'h00;
            4'd1:               b = 8'h09;
            4'd2, 4'd4, 4'd6, 4'd8: b = 8'h0F;
            4'd3, 4'd5, 4'd7, 4'd9: b = 8'hF0;
            4'd12:              b = 8'h01;
            default:            b = 8'h00;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/cfg_hdr_sig_match.sv
`timescale 1ns/1ps
module cfg_hdr_sig_match
    import cfg_hdr_pkg::*;
(
    input  logic [SIG_IDX_W-1:0] idx,
    input  logic [7:0]           data,
    output logic                 match
);
    always_comb begin
        match = (data == sig_byte(idx));
    end
endmodule

// File: rtl/cfg_hdr_dncnt.sv
`timescale 1ns/1ps
module cfg_hdr_dncnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_one
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (dec) begin
            count_q <= count_q - W'(1);
        end
    end

    always_comb begin
        is_one = (count_q == W'(1));
    end

    // R8: a byte is never counted out of an empty remainder
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !clr && !load) |-> (count_q != '0));
endmodule

// File: rtl/cfg_hdr_parser.sv
`timescale 1ns/1ps
module cfg_hdr_parser
    import cfg_hdr_pkg::*;
#(
    parameter int PLEN_W   = 32,
    parameter int INFO_CAP = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    output logic              info_valid,
    output logic [1:0]        info_field,
    output logic              info_first,
    output logic              info_last,
    output logic [7:0]        info_data,
    output logic              pay_valid,
    input  logic              pay_ready,
    output logic [7:0]        pay_data,
    output logic [PLEN_W-1:0] pay_len,
    output logic              hdr_done,
    output logic              done,
    output logic [1:0]        err_code
);
    localparam int PLEN_BYTES = PLEN_W / 8;
    localparam int PB_W       = $clog2(PLEN_BYTES + 1);
    localparam logic [SIG_IDX_W-1:0] SIG_LAST   = SIG_IDX_W'(SIG_BYTES - 1);
    localparam logic [1:0]           FIELD_LAST = 2'(NUM_INFO - 1);
    localparam logic [ILEN_W-1:0]    CAP_V      = ILEN_W'(INFO_CAP);
    localparam logic [PB_W-1:0]      PB_LAST    = PB_W'(PLEN_BYTES - 1);

    state_t                 state_q, state_d;
    logic [SIG_IDX_W-1:0]   sig_idx_q;
    logic [1:0]             field_q;
    logic [7:0]             len_hi_q;
    logic [PB_W-1:0]        pb_cnt_q;
    logic                   first_q;
    err_t                   err_q;
    logic                   hdr_done_q;
    logic                   done_q;
    logic [PLEN_W-1:0]      plen_q;

    logic                   take;
    logic                   sig_ok;
    logic [ILEN_W-1:0]      info_len;
    logic [PLEN_W-1:0]      plen_shift;
    logic                   body_load, pay_load;
    logic                   body_one, pay_one;
    logic                   body_dec, pay_dec;

    assign take       = in_valid && in_ready;
    assign info_len   = {len_hi_q, in_data};
    assign plen_shift = {plen_q[PLEN_W-9:0], in_data};
    assign body_dec   = take && (state_q == ST_BODY);
    assign pay_dec    = take && (state_q == ST_PAY);

    cfg_hdr_sig_match u_sig (
        .idx   (sig_idx_q),
        .data  (in_data),
        .match (sig_ok)
    );

    cfg_hdr_dncnt #(.W(ILEN_W)) u_body_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (restart),
        .load     (body_load),
        .load_val (info_len),
        .dec      (body_dec),
        .is_one   (body_one)
    );

    cfg_hdr_dncnt #(.W(PLEN_W)) u_pay_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (restart),
        .load     (pay_load),
        .load_val (plen_shift),
        .dec      (pay_dec),
        .is_one   (pay_one)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SIG;
        end else if (restart) begin
            state_q <= ST_SIG;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and counter loads
    always_comb begin
        state_d   = state_q;
        body_load = 1'b0;
        pay_load  = 1'b0;
        unique case (state_q)
            ST_SIG: begin
                if (take) begin
                    if (!sig_ok) begin
                        state_d = ST_ERR;
                    end else if (sig_idx_q == SIG_LAST) begin
                        state_d = ST_TAG;
                    end
                end
            end
            ST_TAG: begin
                if (take) state_d = ST_LEN_HI;
            end
            ST_LEN_HI: begin
                if (take) state_d = ST_LEN_LO;
            end
            ST_LEN_LO: begin
                if (take) begin
                    if (info_len >= CAP_V) begin
                        state_d = ST_ERR;
                    end else if (info_len == '0) begin
                        state_d = (field_q == FIELD_LAST) ? ST_LTAG : ST_TAG;
                    end else begin
                        body_load = 1'b1;
                        state_d   = ST_BODY;
                    end
                end
            end
            ST_BODY: begin
                if (take && body_one) begin
                    state_d = (field_q == FIELD_LAST) ? ST_LTAG : ST_TAG;
                end
            end
            ST_LTAG: begin
                if (take) state_d = (in_data == LEN_TAG) ? ST_PLEN : ST_ERR;
            end
            ST_PLEN: begin
                if (take && (pb_cnt_q == PB_LAST)) begin
                    if (plen_shift == '0) begin
                        state_d = ST_SIG;
                    end else begin
                        pay_load = 1'b1;
                        state_d  = ST_PAY;
                    end
                end
            end
            ST_PAY: begin
                if (take && pay_one) state_d = ST_SIG;
            end
            ST_ERR: begin
                state_d = ST_ERR;
            end
            default: begin
                state_d = ST_ERR;
            end
        endcase
    end

    // Header bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_idx_q  <= '0;
            field_q    <= '0;
            len_hi_q   <= '0;
            pb_cnt_q   <= '0;
            first_q    <= 1'b0;
            err_q      <= ERR_NONE;
            hdr_done_q <= 1'b0;
            done_q     <= 1'b0;
            plen_q     <= '0;
        end else if (restart) begin
            sig_idx_q  <= '0;
            field_q    <= '0;
            len_hi_q   <= '0;
            pb_cnt_q   <= '0;
            first_q    <= 1'b0;
            err_q      <= ERR_NONE;
            hdr_done_q <= 1'b0;
            done_q     <= 1'b0;
            plen_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (take) begin
                case (state_q)
                    ST_SIG: begin
                        if (sig_idx_q == '0) begin
                            hdr_done_q <= 1'b0;
                            field_q    <= '0;
                        end
                        if (!sig_ok) begin
                            err_q     <= ERR_MAGIC;
                            sig_idx_q <= '0;
                        end else if (sig_idx_q == SIG_LAST) begin
                            sig_idx_q <= '0;
                        end else begin
                            sig_idx_q <= sig_idx_q + SIG_IDX_W'(1);
                        end
                    end
                    ST_LEN_HI: begin
                        len_hi_q <= in_data;
                    end
                    ST_LEN_LO: begin
                        first_q <= 1'b1;
                        if (info_len >= CAP_V) begin
                            err_q <= ERR_INFO_LEN;
                        end else if (info_len == '0) begin
                            field_q <= field_q + 2'd1;
                        end
                    end
                    ST_BODY: begin
                        first_q <= 1'b0;
                        if (body_one) field_q <= field_q + 2'd1;
                    end
                    ST_LTAG: begin
                        pb_cnt_q <= '0;
                        if (in_data != LEN_TAG) err_q <= ERR_LEN_TAG;
                    end
                    ST_PLEN: begin
                        plen_q   <= plen_shift;
                        pb_cnt_q <= pb_cnt_q + PB_W'(1);
                        if (pb_cnt_q == PB_LAST) begin
                            hdr_done_q <= 1'b1;
                            if (plen_shift == '0) done_q <= 1'b1;
                        end
                    end
                    ST_PAY: begin
                        if (pay_one) done_q <= 1'b1;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_PAY:  in_ready = pay_ready;
            default: in_ready = 1'b1;
        endcase
        info_valid = (state_q == ST_BODY) && in_valid;
        info_data  = in_data;
        info_field = field_q;
        info_first = info_valid && first_q;
        info_last  = info_valid && body_one;
        pay_valid  = (state_q == ST_PAY) && in_valid;
        pay_data   = in_data;
        pay_len    = plen_q;
        hdr_done   = hdr_done_q;
        done       = done_q;
        err_code   = err_q;
    end

    // R10: error code held until restart
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 2'd0 && !restart) |=> (err_code == $past(err_code)));
    // R10: erroneous stream is absorbed silently
    p_err_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 2'd0) |-> (in_ready && !info_valid && !pay_valid));
    // R9: a stalled payload byte is not consumed
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_valid && !pay_ready) |-> !in_ready);
    // R7: payload flows only after the length is known, and the length holds
    p_pay_after_hdr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> hdr_done);
    p_len_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_valid && $past(pay_valid)) |-> $stable(pay_len));
    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4: section markers only accompany a content byte
    p_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (info_first || info_last) |-> info_valid);
endmodule

// File: tb/cfg_hdr_parser_tb.sv
`timescale 1ns/1ps
module cfg_hdr_parser_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'h00;
    logic        info_valid, info_first, info_last;
    logic [1:0]  info_field;
    logic [7:0]  info_data;
    logic        pay_valid;
    logic        pay_ready = 1'b1;
    logic [7:0]  pay_data;
    logic [31:0] pay_len;
    logic        hdr_done, done;
    logic [1:0]  err_code;

    always #2.5 clk = ~clk;

    cfg_hdr_parser dut_i (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .info_valid(info_valid), .info_field(info_field), .info_first(info_first),
        .info_last(info_last), .info_data(info_data),
        .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
        .pay_len(pay_len), .hdr_done(hdr_done), .done(done), .err_code(err_code)
    );

    int nchk = 0;
    int nfail = 0;

    // image and expectations
    logic [7:0] img [0:4095];
    int         img_n;
    int         hdr_last;
    int         ltag_idx;
    int         lenlo_idx [4];
    int         cur_plen;
    logic [7:0] e_info_d [0:2047];
    logic [1:0] e_info_f [0:2047];
    logic       e_info_s [0:2047];
    logic       e_info_e [0:2047];
    int         e_info_n;
    logic [7:0] e_pay [0:2047];
    int         e_pay_n;

    // monitor state
    bit mon_on = 1'b1;
    bit stall_mode = 1'b0;
    int m_info_n, m_pay_n, m_bad, stray, stall_bad;

    function automatic logic [7:0] exp_sig(input int i);
        logic [7:0] v [13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                               8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};
        return v[i];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic add(input logic [7:0] b);
        img[img_n] = b;
        img_n++;
    endtask

    task automatic build(input int l0, input int l1, input int l2, input int l3,
                         input int plen, input logic [7:0] ltag, input int bad_idx);
        int ls [4];
        ls = '{l0, l1, l2, l3};
        img_n = 0; e_info_n = 0; e_pay_n = 0; cur_plen = plen;
        for (int i = 0; i < 13; i++) add((i == bad_idx) ? (exp_sig(i) ^ 8'h5A) : exp_sig(i));
        for (int f = 0; f < 4; f++) begin
            add(8'($urandom));
            add(8'(ls[f] >> 8));
            add(8'(ls[f]));
            lenlo_idx[f] = img_n - 1;
            for (int k = 0; k < ls[f]; k++) begin
                logic [7:0] b;
                b = 8'($urandom);
                add(b);
                e_info_d[e_info_n] = b;
                e_info_f[e_info_n] = 2'(f);
                e_info_s[e_info_n] = (k == 0);
                e_info_e[e_info_n] = (k == ls[f] - 1);
                e_info_n++;
            end
        end
        ltag_idx = img_n;
        add(ltag);
        add(8'(plen >> 24)); add(8'(plen >> 16)); add(8'(plen >> 8)); add(8'(plen));
        hdr_last = img_n - 1;
        for (int k = 0; k < plen; k++) begin
            logic [7:0] b;
            b = 8'($urandom);
            add(b);
            e_pay[e_pay_n] = b;
            e_pay_n++;
        end
    endtask

    task automatic push(input logic [7:0] b);
        bit acc;
        in_data = b;
        in_valid = 1'b1;
        do begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk);
            #1;
        end while (!acc);
        in_valid = 1'b0;
    endtask

    task automatic clear_mon();
        m_info_n = 0; m_pay_n = 0; m_bad = 0; stray = 0; stall_bad = 0;
    endtask

    task automatic run_full(input string tag);
        clear_mon();
        mon_on = 1'b1;
        for (int i = 0; i < img_n; i++) begin
            push(img[i]);
            if (i == hdr_last - 1)
                chk(hdr_done == 1'b0, "R7", {tag, " hdr_done early"}, hdr_done, 0);
            if (i == hdr_last) begin
                chk(hdr_done == 1'b1, "R7", {tag, " hdr_done"}, hdr_done, 1);
                chk(pay_len == 32'(cur_plen), "R7", {tag, " pay_len"}, pay_len, cur_plen);
            end
        end
        chk(done == 1'b1, "R8", {tag, " done pulse"}, done, 1);
        @(posedge clk); #1;
        chk(done == 1'b0, "R8", {tag, " done width"}, done, 0);
        chk(m_info_n == e_info_n && m_bad == 0, "R3", {tag, " info stream"}, m_bad, 0);
        chk(m_info_n == e_info_n, "R4", {tag, " info count"}, m_info_n, e_info_n);
        chk(m_pay_n == e_pay_n, "R8", {tag, " payload count"}, m_pay_n, e_pay_n);
        chk(stall_bad == 0, "R9", {tag, " ready follows stall"}, stall_bad, 0);
        chk(err_code == 2'd0, "R2", {tag, " no error"}, err_code, 0);
    endtask

    task automatic run_partial(input int n);
        for (int i = 0; i < n; i++) push(img[i]);
    endtask

    task automatic do_restart();
        restart = 1'b1;
        @(posedge clk); #1;
        restart = 1'b0;
    endtask

    task automatic check_idle(input string tag);
        chk(in_ready && err_code == 0 && !hdr_done && pay_len == 0 && !done &&
            !info_valid && !pay_valid, "R1", tag, {err_code, hdr_done}, 0);
    endtask

    task automatic junk_after_error(input logic [1:0] code, input string req);
        mon_on = 1'b0;
        clear_mon();
        for (int i = 0; i < 30; i++) push(8'($urandom));
        chk(stray == 0, "R10", "no output after error", stray, 0);
        chk(err_code == code, "R10", {"sticky code after ", req}, err_code, code);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (info_valid) begin
                if (!mon_on) stray++;
                else if (m_info_n >= e_info_n || info_data != e_info_d[m_info_n] ||
                         info_field != e_info_f[m_info_n] || info_first != e_info_s[m_info_n] ||
                         info_last != e_info_e[m_info_n]) m_bad++;
                m_info_n++;
            end
            if (pay_valid) begin
                if (!mon_on) stray++;
                if (in_ready != pay_ready) stall_bad++;
                if (pay_ready) begin
                    if (mon_on && (m_pay_n >= e_pay_n || pay_data != e_pay[m_pay_n])) m_bad++;
                    m_pay_n++;
                end
            end
        end
    end

    // downstream back-pressure
    initial begin
        forever begin
            @(posedge clk); #1;
            pay_ready = stall_mode ? (($urandom % 4) != 0) : 1'b1;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        check_idle("state after reset");

        // R3 R4: ordinary image, mixed section lengths
        build(5, 7, 3, 4, 10, 8'h65, -1);
        run_full("basic");

        // R4: zero-length sections produce nothing
        build(0, 3, 0, 1, 6, 8'h65, -1);
        run_full("zero sections");

        // R8: zero payload
        build(2, 2, 2, 2, 0, 8'h65, -1);
        run_full("zero payload");

        // R5: largest legal section length
        build(255, 1, 1, 1, 3, 8'h65, -1);
        run_full("len 255");

        // R2: bad signature byte
        build(1, 1, 1, 1, 1, 8'h65, 6);
        run_partial(7);
        chk(err_code == 2'd1, "R2", "signature mismatch code", err_code, 1);
        junk_after_error(2'd1, "R2");
        do_restart();
        check_idle("state after restart");

        // R5: oversize section
        build(1, 256, 1, 1, 1, 8'h65, -1);
        run_partial(lenlo_idx[1] + 1);
        chk(err_code == 2'd2, "R5", "section 256 code", err_code, 2);
        junk_after_error(2'd2, "R5");
        do_restart();

        // R6: wrong length tag
        build(1, 1, 1, 1, 4, 8'h66, -1);
        run_partial(ltag_idx + 1);
        chk(err_code == 2'd3, "R6", "length tag code", err_code, 3);
        junk_after_error(2'd3, "R6");
        do_restart();

        // R9: random images with downstream stalls
        stall_mode = 1'b1;
        for (int n = 0; n < 10; n++) begin
            build(int'($urandom % 20), int'($urandom % 20), int'($urandom % 20),
                  int'($urandom % 20), int'($urandom % 60), 8'h65, -1);
            run_full("random");
        end
        stall_mode = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule